// File: doc/BRIEF.md
# Slow-Clock Seconds Counter with Trim

The block keeps a 32-bit count of seconds that runs from a slow, always-on oscillator of nominally 32.768 kHz. A programmable prescaler divides the oscillator down to the counter tick. The tick period is the trim value plus one slow cycles, so a trim of 32767 gives one tick per second. The counter and prescaler live entirely in the slow domain, so they go on counting while the fast system clock is stopped.

A fast bus-side interface drives three write strobes: load the count, load the trim, and write the control bit that enables counting. It reads back a synchronized snapshot of the count, the last accepted trim, the enable state, a slow-clock-present flag and two pending flags. Count and trim writes cross into the slow domain through toggle handshakes. While a write is in flight its pending flag is high, and further writes to that register are dropped.

A count write lands within a few slow cycles. A trim write is only taken at the next prescaler rollover, which can be up to trim+1 slow cycles away. The bus side never waits: software polls the pending flags. A watchdog in the bus domain counts slow-clock edges per fixed window and reports whether the oscillator is running.

Top module: `secs_counter`

## Requirements
- R1: While enabled, the count rises by exactly one every trim+1 slow-clock cycles; a trim of 32767 makes this one tick per 32768 slow cycles.
- R2: An accepted count write loads the written 32-bit value and restarts the prescaler from zero, and `countValue` then shows exactly that value.
- R3: A `wrCtrl` strobe sets `enabled` from `wrData` bit 0 on the following bus cycle. While `enabled` is low the count and prescaler hold, and `countValue` stays constant.
- R4: `countBusy` rises the bus cycle after an accepted count write and falls only after the slow domain has acknowledged it. A count write made while `countBusy` is high has no effect on the count.
- R5: `trimBusy` rises the bus cycle after an accepted trim write (`wrData` bits TRIM_W-1:0) and stays high until a prescaler rollover takes the new value, so it stays high while counting is disabled. A trim write made while `trimBusy` is high is dropped, and `trimValue` keeps the last accepted trim.
- R6: A new trim takes effect at the next rollover, after which ticks follow the new period.
- R7: The count wraps from 32'hFFFF_FFFF to zero.
- R8: At the end of each DET_WINDOW-cycle bus window, `clkOk` is set if at least DET_MIN_EDGES slow-clock rising edges were seen in that window and cleared otherwise.
- R9: `countValue` is updated only from a slow-domain snapshot held stable across a full toggle handshake, so every bit pattern read equals a value the counter actually held.
- R10: After reset, `countValue` is 0, `trimValue` is TRIM_RESET, and `enabled`, `clkOk`, `countBusy` and `trimBusy` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Fast bus-domain clock |
| slowClk | input | 1 | Slow always-on oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| wrCount | input | 1 | Strobe: load count from wrData |
| wrTrim | input | 1 | Strobe: load trim from wrData[TRIM_W-1:0] |
| wrCtrl | input | 1 | Strobe: set enable from wrData[0] |
| wrData | input | CNT_W | Write data for all strobes |
| countValue | output | CNT_W | Synchronized count snapshot |
| trimValue | output | TRIM_W | Last accepted trim value |
| enabled | output | 1 | Counter enable state |
| clkOk | output | 1 | Slow clock detected |
| countBusy | output | 1 | Count write pending |
| trimBusy | output | 1 | Trim write pending |

## Verification
On every bus cycle the assertions check that each pending flag rises only as a result of a write strobe, that a trim write during a pending trim leaves `trimValue` untouched, and that `enabled` follows the control strobe. Tick rate, the rollover timing of trim changes, the wrap, holding while disabled, oscillator-loss detection and the exact readback of loaded values span both clock domains over many slow cycles. Only the bench scenarios, which measure counts over long intervals, can show these.

// File: rtl/secs_counter_pkg.sv
package secs_counter_pkg;
  // Strobes from the slow-domain control into the datapath
  typedef struct packed {
    logic loadCount;    // take the bus-held count, restart prescaler
    logic captureTrim;  // stage the bus-held trim
    logic tick;         // prescaler rollover, advance the count
    logic applyTrim;    // move staged trim into the active divider
  } ctlStrobe_t;
endpackage

// File: rtl/secs_counter_sync.sv
module secs_counter_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/secs_counter_bus.sv
module secs_counter_bus #(
  parameter int CNT_W         = 32,
  parameter int TRIM_W        = 16,
  parameter int TRIM_RESET    = 32767,
  parameter int SYNC_STAGES   = 2,
  parameter int DET_WINDOW    = 256,
  parameter int DET_MIN_EDGES = 4
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              slowClk,
  input  logic              wrCount,
  input  logic              wrTrim,
  input  logic              wrCtrl,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              countAckTgl,
  input  logic              trimAckTgl,
  input  logic              snapTgl,
  input  logic [CNT_W-1:0]  snapData,
  output logic [CNT_W-1:0]  countHold,
  output logic              countReqTgl,
  output logic              trimReqTgl,
  output logic              snapAckTgl,
  output logic [CNT_W-1:0]  countValue,
  output logic [TRIM_W-1:0] trimValue,
  output logic              enabled,
  output logic              clkOk,
  output logic              countBusy,
  output logic              trimBusy
);
  localparam int WIN_W  = $clog2(DET_WINDOW);
  localparam int EDGE_W = $clog2(DET_WINDOW + 1);

  logic countAckS, trimAckS, snapTglS, slowS;
  logic slowPrev, slowEdge, winEnd;
  logic [WIN_W-1:0]  winCnt;
  logic [EDGE_W-1:0] edgeCnt;

  secs_counter_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_syncBus (
    .clk (busClk),
    .rstN(rstN),
    .d   ({countAckTgl, trimAckTgl, snapTgl, slowClk}),
    .q   ({countAckS, trimAckS, snapTglS, slowS})
  );

  assign countBusy = countReqTgl ^ countAckS;
  assign trimBusy  = trimReqTgl ^ trimAckS;

  // Write registers: a write is taken only when its register is idle
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      countHold   <= '0;
      countReqTgl <= 1'b0;
      trimValue   <= TRIM_W'(TRIM_RESET);
      trimReqTgl  <= 1'b0;
      enabled     <= 1'b0;
    end else begin
      if (wrCount && !countBusy) begin
        countHold   <= wrData;
        countReqTgl <= ~countReqTgl;
      end
      if (wrTrim && !trimBusy) begin
        trimValue  <= wrData[TRIM_W-1:0];
        trimReqTgl <= ~trimReqTgl;
      end
      if (wrCtrl) enabled <= wrData[0];
    end
  end

  // Snapshot capture: data is stable while the toggles differ
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      countValue <= '0;
      snapAckTgl <= 1'b0;
    end else if (snapTglS != snapAckTgl) begin
      countValue <= snapData;
      snapAckTgl <= snapTglS;
    end
  end

  // Oscillator watchdog: count slow rising edges per window
  assign slowEdge = slowS & ~slowPrev;
  assign winEnd   = (winCnt == WIN_W'(DET_WINDOW - 1));

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      slowPrev <= 1'b0;
      winCnt   <= '0;
      edgeCnt  <= '0;
      clkOk    <= 1'b0;
    end else begin
      slowPrev <= slowS;
      if (winEnd) begin
        winCnt  <= '0;
        edgeCnt <= '0;
        clkOk   <= (edgeCnt + EDGE_W'(slowEdge)) >= EDGE_W'(DET_MIN_EDGES);
      end else begin
        winCnt <= winCnt + WIN_W'(1);
        if (slowEdge) edgeCnt <= edgeCnt + EDGE_W'(1);
      end
    end
  end
endmodule

// File: rtl/secs_counter_ctrl.sv
module secs_counter_ctrl
  import secs_counter_pkg::*;
(
  input  logic       slowClk,
  input  logic       rstN,
  input  logic       enS,
  input  logic       countReqS,
  input  logic       trimReqS,
  input  logic       atTop,
  output ctlStrobe_t strobe,
  output logic       countAckTgl,
  output logic       trimAckTgl
);
  logic trimSeen, trimPend;

  always_comb begin
    strobe.loadCount   = countReqS != countAckTgl;
    strobe.captureTrim = trimReqS != trimSeen;
    strobe.tick        = enS && atTop && !strobe.loadCount;
    strobe.applyTrim   = strobe.tick && trimPend;
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      countAckTgl <= 1'b0;
      trimAckTgl  <= 1'b0;
      trimSeen    <= 1'b0;
      trimPend    <= 1'b0;
    end else begin
      if (strobe.loadCount) countAckTgl <= countReqS;
      if (strobe.applyTrim) begin
        trimPend   <= 1'b0;
        trimAckTgl <= trimSeen;
      end
      if (strobe.captureTrim) begin
        trimSeen <= trimReqS;
        trimPend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/secs_counter_datapath.sv
module secs_counter_datapath
  import secs_counter_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int TRIM_W     = 16,
  parameter int TRIM_RESET = 32767
) (
  input  logic              slowClk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              enS,
  input  logic [CNT_W-1:0]  countHold,
  input  logic [TRIM_W-1:0] trimHold,
  input  logic              snapAckS,
  output logic              atTop,
  output logic              snapTgl,
  output logic [CNT_W-1:0]  snapData
);
  logic [CNT_W-1:0]  count;
  logic [TRIM_W-1:0] pre, trimActive, trimStaged;

  assign atTop = (pre == trimActive);

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      pre   <= '0;
    end else if (strobe.loadCount) begin
      count <= countHold;
      pre   <= '0;
    end else if (strobe.tick) begin
      count <= count + CNT_W'(1);
      pre   <= '0;
    end else if (enS) begin
      pre <= pre + TRIM_W'(1);
    end
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      trimActive <= TRIM_W'(TRIM_RESET);
      trimStaged <= TRIM_W'(TRIM_RESET);
    end else begin
      if (strobe.applyTrim)   trimActive <= trimStaged;
      if (strobe.captureTrim) trimStaged <= trimHold;
    end
  end

  // Publish a new snapshot only once the previous one was acknowledged
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      snapData <= '0;
      snapTgl  <= 1'b0;
    end else if ((snapAckS == snapTgl) && (snapData != count)) begin
      snapData <= count;
      snapTgl  <= ~snapTgl;
    end
  end
endmodule

// File: rtl/secs_counter.sv
module secs_counter
  import secs_counter_pkg::*;
#(
  parameter int CNT_W         = 32,
  parameter int TRIM_W        = 16,
  parameter int TRIM_RESET    = 32767,
  parameter int SYNC_STAGES   = 2,
  parameter int DET_WINDOW    = 256,
  parameter int DET_MIN_EDGES = 4
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              wrCount,
  input  logic              wrTrim,
  input  logic              wrCtrl,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  countValue,
  output logic [TRIM_W-1:0] trimValue,
  output logic              enabled,
  output logic              clkOk,
  output logic              countBusy,
  output logic              trimBusy
);
  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] countHold, snapData;
  logic countReqTgl, trimReqTgl, snapAckTgl;
  logic countAckTgl, trimAckTgl, snapTgl;
  logic enS, countReqS, trimReqS, snapAckS, atTop;

  secs_counter_bus #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET),
    .SYNC_STAGES(SYNC_STAGES), .DET_WINDOW(DET_WINDOW),
    .DET_MIN_EDGES(DET_MIN_EDGES)
  ) u_bus (
    .busClk(busClk), .rstN(rstN), .slowClk(slowClk),
    .wrCount(wrCount), .wrTrim(wrTrim), .wrCtrl(wrCtrl), .wrData(wrData),
    .countAckTgl(countAckTgl), .trimAckTgl(trimAckTgl),
    .snapTgl(snapTgl), .snapData(snapData),
    .countHold(countHold), .countReqTgl(countReqTgl),
    .trimReqTgl(trimReqTgl), .snapAckTgl(snapAckTgl),
    .countValue(countValue), .trimValue(trimValue), .enabled(enabled),
    .clkOk(clkOk), .countBusy(countBusy), .trimBusy(trimBusy)
  );

  secs_counter_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_syncSlow (
    .clk (slowClk),
    .rstN(rstN),
    .d   ({enabled, countReqTgl, trimReqTgl, snapAckTgl}),
    .q   ({enS, countReqS, trimReqS, snapAckS})
  );

  secs_counter_ctrl u_ctrl (
    .slowClk(slowClk), .rstN(rstN), .enS(enS),
    .countReqS(countReqS), .trimReqS(trimReqS), .atTop(atTop),
    .strobe(strobe), .countAckTgl(countAckTgl), .trimAckTgl(trimAckTgl)
  );

  secs_counter_datapath #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .TRIM_RESET(TRIM_RESET)
  ) u_data (
    .slowClk(slowClk), .rstN(rstN), .strobe(strobe), .enS(enS),
    .countHold(countHold), .trimHold(trimValue), .snapAckS(snapAckS),
    .atTop(atTop), .snapTgl(snapTgl), .snapData(snapData)
  );
endmodule

// File: rtl/secs_counter_check.sv
module secs_counter_check #(
  parameter int TRIM_W = 16
) (
  input logic              busClk,
  input logic              rstN,
  input logic              wrCount,
  input logic              wrTrim,
  input logic              wrCtrl,
  input logic              wrData0,
  input logic              enabled,
  input logic              countBusy,
  input logic              trimBusy,
  input logic [TRIM_W-1:0] trimValue
);
  assert_count_busy_cause_R4: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(countBusy) |-> $past(wrCount));

  assert_trim_busy_cause_R5: assert property (@(posedge busClk) disable iff (!rstN)
    $rose(trimBusy) |-> $past(wrTrim));

  assert_trim_write_dropped_R5: assert property (@(posedge busClk) disable iff (!rstN)
    (wrTrim && trimBusy) |=> $stable(trimValue));

  assert_enable_follows_R3: assert property (@(posedge busClk) disable iff (!rstN)
    wrCtrl |=> (enabled == $past(wrData0)));
endmodule

bind secs_counter secs_counter_check #(.TRIM_W(TRIM_W)) u_check (
  .busClk(busClk), .rstN(rstN), .wrCount(wrCount), .wrTrim(wrTrim),
  .wrCtrl(wrCtrl), .wrData0(wrData[0]), .enabled(enabled),
  .countBusy(countBusy), .trimBusy(trimBusy), .trimValue(trimValue)
);

// File: tb/test_secs_counter.sv
`timescale 1ns/1ps
module test_secs_counter;
  localparam int CNT_W = 32;
  localparam int TRIM_W = 16;
  localparam int TRIM_RST = 7;

  logic busClk = 1'b0, slowClk = 1'b0, slowRun = 1'b1, rstN = 1'b0;
  logic wrCount = 1'b0, wrTrim = 1'b0, wrCtrl = 1'b0;
  logic [CNT_W-1:0]  wrData = '0;
  logic [CNT_W-1:0]  countValue;
  logic [TRIM_W-1:0] trimValue;
  logic enabled, clkOk, countBusy, trimBusy;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  localparam logic [31:0] VEC [4] = '{32'h0000_0000, 32'h1234_5678,
                                      32'hFFFF_FFFF, 32'h8000_0001};

  secs_counter #(.TRIM_RESET(TRIM_RST)) i_secs_counter (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN),
    .wrCount(wrCount), .wrTrim(wrTrim), .wrCtrl(wrCtrl), .wrData(wrData),
    .countValue(countValue), .trimValue(trimValue), .enabled(enabled),
    .clkOk(clkOk), .countBusy(countBusy), .trimBusy(trimBusy)
  );

  always #2.5 busClk = ~busClk;
  initial forever begin
    #25;
    if (slowRun) slowClk = ~slowClk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input logic [31:0] act,
                            input logic [31:0] lo, input logic [31:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic waitBus(input int n);
    repeat (n) @(negedge busClk);
  endtask

  // kind: 0 count, 1 trim, 2 control
  task automatic busWrite(input int kind, input logic [31:0] data);
    @(negedge busClk);
    wrData  = data;
    wrCount = (kind == 0);
    wrTrim  = (kind == 1);
    wrCtrl  = (kind == 2);
    @(negedge busClk);
    wrCount = 1'b0; wrTrim = 1'b0; wrCtrl = 1'b0;
  endtask

  task automatic waitTrimIdle();
    for (int i = 0; i < 3000 && trimBusy; i++) @(negedge busClk);
  endtask

  task automatic waitCountIdle();
    for (int i = 0; i < 3000 && countBusy; i++) @(negedge busClk);
  endtask

  initial begin
    repeat (150000) @(posedge busClk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] c0, c1;
    waitBus(10);
    rstN = 1'b1;
    @(negedge busClk);
    // R10 reset state
    check("R10 count", countValue, 32'h0);
    check("R10 trim", 32'(trimValue), 32'(TRIM_RST));
    check("R10 enable", 32'(enabled), 32'h0);
    check("R10 clkOk", 32'(clkOk), 32'h0);
    check("R10 busy", 32'({countBusy, trimBusy}), 32'h0);

    // R8 oscillator seen after a full window
    waitBus(600);
    check("R8 clkOk running", 32'(clkOk), 32'h1);

    // R2 R9 vector table: exact loads while disabled
    for (int i = 0; i < 4; i++) begin
      busWrite(0, VEC[i]);
      check("R4 busy after write", 32'(countBusy), 32'h1);
      waitBus(200);
      check("R4 busy cleared", 32'(countBusy), 32'h0);
      check("R2 loaded value", countValue, VEC[i]);
    end

    // R4 write during pending count write is dropped
    busWrite(0, 32'h0000_00AA);
    busWrite(0, 32'h0000_00BB);
    waitBus(200);
    check("R4 second write dropped", countValue, 32'h0000_00AA);

    // R5 trim pending while disabled; second write dropped
    busWrite(1, 32'd3);
    waitBus(300);
    check("R5 trim held pending while disabled", 32'(trimBusy), 32'h1);
    busWrite(1, 32'd9);
    check("R5 trimValue keeps accepted", 32'(trimValue), 32'd3);

    // R3 enable, trim lands at rollover (R6)
    busWrite(2, 32'h1);
    check("R3 enabled", 32'(enabled), 32'h1);
    waitBus(300);
    check("R6 trim applied at rollover", 32'(trimBusy), 32'h0);

    // R1 rate with trim 3: 400 slow cycles -> 100 ticks
    c0 = countValue;
    waitBus(4000);
    c1 = countValue;
    checkRange("R1 tick rate trim 3", c1 - c0, 32'd99, 32'd101);

    // R7 wrap through all-ones
    busWrite(0, 32'hFFFF_FFFE);
    waitCountIdle();
    waitBus(160);
    checkRange("R7 wrapped", countValue, 32'd0, 32'd3);

    // R6 change rate while running: trim 1 -> 200 ticks in 400 slow cycles
    busWrite(1, 32'd1);
    waitTrimIdle();
    check("R6 trim accepted", 32'(trimBusy), 32'h0);
    c0 = countValue;
    waitBus(4000);
    c1 = countValue;
    checkRange("R6 tick rate trim 1", c1 - c0, 32'd199, 32'd201);

    // R3 hold while disabled, then resume
    busWrite(2, 32'h0);
    check("R3 disabled", 32'(enabled), 32'h0);
    waitBus(100);
    c0 = countValue;
    waitBus(1000);
    check("R3 count holds", countValue, c0);
    busWrite(2, 32'h1);
    waitBus(400);
    checkRange("R3 resumes", countValue - c0, 32'd10, 32'd30);

    // R8 oscillator loss; R4 write stays pending without stalling the bus
    slowRun = 1'b0;
    waitBus(700);
    check("R8 clkOk lost", 32'(clkOk), 32'h0);
    c0 = countValue;
    busWrite(0, 32'h5);
    waitBus(500);
    check("R4 pending while stopped", 32'(countBusy), 32'h1);
    check("R4 count unchanged while stopped", countValue, c0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule